// File: doc/BRIEF.md
# Lane-Parallel Multi-Mode Address Generator

This block produces one vector of memory addresses per clock, one address per lane, to assemble an N-wide data vector from a banked buffer. Lane `i` always addresses bank `i`, so a group of N addresses can never collide on a bank. Each lane holds its own small register file of base, stride and scale operands. Each lane also has a dedicated integer affine unit that computes `base + coefficient * operand`, so address arithmetic never touches the data path.

Software loads the lane registers, the addressing mode and the element count through a configuration port while the block is idle, then pulses `start`. The block then emits one group per cycle until the element count is covered. Three modes exist: sequential, strided, and gather. In gather mode, per-lane indices arrive on `idx_i` in the cycles flagged by `idx_take_o`. Lanes past the last element stay invalid in the final group, and a one-cycle `done_o` pulse marks the end of the stream.

Top module: `agu_multimode`

## Requirements
- R1: While reset is applied and after its release, `valid_o`, `done_o` and `idx_take_o` are all low.
- R2: In sequential mode (mode code 0), lane `i` in group `k` outputs `base_i + k*LANES + i`, modulo 2^ADDR_W.
- R3: In strided mode (mode code 1), lane `i` in group `k` outputs `base_i + (k*LANES + i) * stride_i`, modulo 2^ADDR_W.
- R4: In gather mode (mode code 2), lane `i` outputs `base_i + idx * scale_i`, modulo 2^ADDR_W. Here `idx` is the unsigned value of `idx_i[i*IDX_W +: IDX_W]` sampled on the edge that closes a cycle in which `idx_take_o` is high.
- R5: A `start` accepted on edge E0 raises `idx_take_o` for the cycle after E0. Group 0 is visible after E1, and each further group one cycle after the one before. `idx_take_o` is high exactly in the cycles whose closing edge computes a group.
- R6: In group `k`, lane `i` is valid only when `k*LANES + i < count`. The valid lanes are therefore always a contiguous run starting at lane 0.
- R7: `done_o` is high for exactly one cycle, which is the cycle after the last group is shown. In that cycle all `valid_o` bits are low.
- R8: A `start` with a count of zero produces no valid lane, and `done_o` is high in the cycle after E1.
- R9: From the accepting edge until `done_o` falls, configuration writes and further `start` pulses have no effect, on this stream or on the next one.
- R10: Mode code 3 behaves exactly as sequential mode.
- R11: `cfg_field` codes are: 0 base, 1 stride, 2 scale (each written to the lanes set in `cfg_lane_mask`), 3 mode (low two data bits), 4 count (low CNT_W data bits). Codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 3 | Target field code |
| cfg_lane_mask | input | LANES | Lanes receiving a base/stride/scale write |
| cfg_wdata | input | ADDR_W | Write data |
| start | input | 1 | Begin a stream when idle |
| idx_i | input | LANES*IDX_W | Gather indices, lane i in slice i |
| idx_take_o | output | 1 | Indices are consumed at the coming edge |
| addr_o | output | LANES*ADDR_W | Per-lane addresses, lane i in slice i |
| valid_o | output | LANES | Per-lane address valid |
| done_o | output | 1 | One-cycle end-of-stream pulse |

## Verification
The bound checker watches the stream framing on every cycle. It checks that the valid lanes form a contiguous run from lane 0, that a valid group always follows an index-take cycle, and that `done_o` is a single pulse with no valid lane beside it, following the last take cycle. It also checks that mode and count stay frozen while a stream runs. The address values themselves are shown only by the bench scenarios: sequential, strided and gather arithmetic with per-lane operands and wrap-around, partial and exact final groups, a zero count, the reserved mode code, and writes or restarts issued mid-stream.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      MODE_SEQ    = 2'd0,
      MODE_STRIDE = 2'd1,
      MODE_GATHER = 2'd2,
      MODE_RSVD   = 2'd3
   } agu_mode_e;

   typedef enum logic [2:0] {
      FLD_BASE   = 3'd0,
      FLD_STRIDE = 3'd1,
      FLD_SCALE  = 3'd2,
      FLD_MODE   = 3'd3,
      FLD_COUNT  = 3'd4
   } agu_field_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } agu_state_e;

endpackage

// File: rtl/agu_lane_rf.sv
module agu_lane_rf
   import agu_pkg::*;
#(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   field,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] base_q,
   output logic [W-1:0] stride_q,
   output logic [W-1:0] scale_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         stride_q <= '0;
         scale_q  <= '0;
      end else if (wr_en) begin
         if (field == FLD_BASE)   base_q   <= wdata;
         if (field == FLD_STRIDE) stride_q <= wdata;
         if (field == FLD_SCALE)  scale_q  <= wdata;
      end
   end

endmodule

// File: rtl/agu_affine.sv
module agu_affine #(
   parameter int W = 20
) (
   input  logic [W-1:0] base,
   input  logic [W-1:0] coef,
   input  logic [W-1:0] opnd,
   output logic [W-1:0] addr
);

   logic [2*W-1:0] prod;

   always_comb begin
      prod = {{W{1'b0}}, coef} * {{W{1'b0}}, opnd};
      addr = base + prod[W-1:0];
   end

endmodule

// File: rtl/agu_seq.sv
module agu_seq
   import agu_pkg::*;
#(
   parameter int LANES = 4,
   parameter int CNT_W = 12,
   localparam int GRP_W = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_field,
   input  logic [1:0]       cfg_mode,
   input  logic [CNT_W-1:0] cfg_count,
   output agu_mode_e        mode_q,
   output logic [CNT_W-1:0] count_q,
   output logic [GRP_W-1:0] grp_base,
   output logic             step,
   output logic             fin,
   output logic             idle,
   output logic             done
);

   agu_state_e       state;
   logic [GRP_W-1:0] grp_next;

   assign grp_next = grp_base + GRP_W'(LANES);
   assign step     = (state == ST_RUN);
   assign fin      = (state == ST_FIN);
   assign idle     = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         grp_base <= '0;
         done     <= 1'b0;
         mode_q   <= MODE_SEQ;
         count_q  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (cfg_we && cfg_field == FLD_MODE)  mode_q  <= agu_mode_e'(cfg_mode);
               if (cfg_we && cfg_field == FLD_COUNT) count_q <= cfg_count;
               if (start) begin
                  grp_base <= '0;
                  state    <= (count_q == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               grp_base <= grp_next;
               if (grp_next >= {1'b0, count_q}) state <= ST_FIN;
            end
            ST_FIN: begin
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/agu_multimode.sv
module agu_multimode
   import agu_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int ADDR_W     = 20,
   parameter int IDX_W      = 8,
   parameter int CNT_W      = 12,
   parameter bit SIGNED_IDX = 1'b0,
   localparam int GRP_W     = CNT_W + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [2:0]              cfg_field,
   input  logic [LANES-1:0]        cfg_lane_mask,
   input  logic [ADDR_W-1:0]       cfg_wdata,
   input  logic                    start,
   input  logic [LANES*IDX_W-1:0]  idx_i,
   output logic                    idx_take_o,
   output logic [LANES*ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]        valid_o,
   output logic                    done_o
);

   if (LANES < 1 || LANES > (1 << CNT_W)) begin : g_bad_lanes
      $error("agu_multimode: LANES out of range");
   end
   if (ADDR_W <= GRP_W) begin : g_bad_addr
      $error("agu_multimode: ADDR_W must exceed CNT_W+1");
   end
   if (ADDR_W <= IDX_W || IDX_W < 1) begin : g_bad_idx
      $error("agu_multimode: IDX_W must be below ADDR_W");
   end

   agu_mode_e        mode_q;
   logic [CNT_W-1:0] count_q;
   logic [GRP_W-1:0] grp_base;
   logic             step, fin, idle;

   agu_seq #(.LANES(LANES), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg_we    (cfg_we),
      .cfg_field (cfg_field),
      .cfg_mode  (cfg_wdata[1:0]),
      .cfg_count (cfg_wdata[CNT_W-1:0]),
      .mode_q    (mode_q),
      .count_q   (count_q),
      .grp_base  (grp_base),
      .step      (step),
      .fin       (fin),
      .idle      (idle),
      .done      (done_o)
   );

   assign idx_take_o = step;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [ADDR_W-1:0] base_q, stride_q, scale_q;
      logic [ADDR_W-1:0] coef, opnd, idx_ext, elem_ext, addr_c;
      logic [GRP_W-1:0]  elem;
      logic [IDX_W-1:0]  idx;
      logic              lane_wr;
      logic              in_range;

      assign lane_wr = cfg_we && idle && cfg_lane_mask[i];
      assign elem    = grp_base + GRP_W'(i);
      assign idx     = idx_i[i*IDX_W +: IDX_W];
      assign elem_ext = {{(ADDR_W-GRP_W){1'b0}}, elem};
      assign in_range = (elem < {1'b0, count_q});

      if (SIGNED_IDX) begin : g_sx
         assign idx_ext = {{(ADDR_W-IDX_W){idx[IDX_W-1]}}, idx};
      end else begin : g_zx
         assign idx_ext = {{(ADDR_W-IDX_W){1'b0}}, idx};
      end

      agu_lane_rf #(.W(ADDR_W)) u_rf (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (lane_wr),
         .field    (cfg_field),
         .wdata    (cfg_wdata),
         .base_q   (base_q),
         .stride_q (stride_q),
         .scale_q  (scale_q)
      );

      always_comb begin
         unique case (mode_q)
            MODE_STRIDE: begin coef = stride_q;          opnd = elem_ext; end
            MODE_GATHER: begin coef = scale_q;           opnd = idx_ext;  end
            default:     begin coef = ADDR_W'(1);        opnd = elem_ext; end
         endcase
      end

      agu_affine #(.W(ADDR_W)) u_alu (
         .base (base_q),
         .coef (coef),
         .opnd (opnd),
         .addr (addr_c)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_o[i*ADDR_W +: ADDR_W] <= '0;
            valid_o[i]                 <= 1'b0;
         end else if (step) begin
            addr_o[i*ADDR_W +: ADDR_W] <= addr_c;
            valid_o[i]                 <= in_range;
         end else if (fin) begin
            valid_o[i]                 <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/agu_multimode_chk.sv
module agu_multimode_chk
   import agu_pkg::*;
#(
   parameter int LANES = 4,
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LANES-1:0] valid_o,
   input logic             done_o,
   input logic             idx_take_o,
   input logic             idle,
   input agu_mode_e        mode_q,
   input logic [CNT_W-1:0] count_q
);

   AST_VALID_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      ((valid_o & (valid_o + LANES'(1))) == '0)); // R6

   AST_VALID_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (|valid_o) |-> $past(idx_take_o)); // R5

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R7

   AST_DONE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (valid_o == '0)); // R7

   AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idx_take_o) |=> done_o); // R7

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(mode_q) && $stable(count_q))); // R9

endmodule

bind agu_multimode agu_multimode_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_o    (valid_o),
   .done_o     (done_o),
   .idx_take_o (idx_take_o),
   .idle       (idle),
   .mode_q     (mode_q),
   .count_q    (count_q)
);

// File: tb/agu_multimode_test.sv
module agu_multimode_test;

   localparam int L  = 4;
   localparam int AW = 20;
   localparam int IW = 8;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_field = '0;
   logic [L-1:0]  cfg_lane_mask = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          start = 1'b0;
   logic [L*IW-1:0] idx_i = '0;
   logic          idx_take_o;
   logic [L*AW-1:0] addr_o;
   logic [L-1:0]  valid_o;
   logic          done_o;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [AW-1:0] lb [L];
   logic [AW-1:0] ls [L];
   logic [AW-1:0] lc [L];
   logic [1:0]    cur_mode;
   int            cur_cnt;

   always #10 clk = ~clk;

   agu_multimode uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_field(cfg_field),
      .cfg_lane_mask(cfg_lane_mask), .cfg_wdata(cfg_wdata), .start(start),
      .idx_i(idx_i), .idx_take_o(idx_take_o), .addr_o(addr_o),
      .valid_o(valid_o), .done_o(done_o)
   );

   // mode, count, base, stride, scale
   localparam logic [73:0] VECS [7] = '{
      {2'd0, 12'd10, 20'h00100, 20'h00000, 20'h00000},
      {2'd1, 12'd8,  20'h02000, 20'h00003, 20'h00000},
      {2'd2, 12'd7,  20'h04000, 20'h00000, 20'h00004},
      {2'd3, 12'd5,  20'h00050, 20'h00009, 20'h00007},
      {2'd1, 12'd9,  20'hFFF00, 20'h01000, 20'h00000},
      {2'd0, 12'd1,  20'h00777, 20'h00000, 20'h00000},
      {2'd2, 12'd12, 20'h00000, 20'h00000, 20'hFFFFF}
   };

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] exp_addr(input logic [1:0] m, input int e,
      input logic [AW-1:0] b, input logic [AW-1:0] st, input logic [AW-1:0] sc,
      input logic [IW-1:0] ix);
      logic [63:0] r;
      case (m)
         2'd1:    r = 64'(b) + 64'(e) * 64'(st);
         2'd2:    r = 64'(b) + 64'(ix) * 64'(sc);
         default: r = 64'(b) + 64'(e);
      endcase
      return r[AW-1:0];
   endfunction

   function automatic logic [IW-1:0] gidx(input int k, input int i);
      return IW'((k * 7 + i * 13 + 3) % 256);
   endfunction

   task automatic cfg_write(input logic [2:0] f, input logic [L-1:0] m, input logic [AW-1:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_field = f; cfg_lane_mask = m; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic configure(input logic [1:0] m, input int cnt, input logic [AW-1:0] b,
                            input logic [AW-1:0] st, input logic [AW-1:0] sc);
      for (int i = 0; i < L; i++) begin
         lb[i] = b + AW'(i * 'h100);
         ls[i] = st + AW'(i);
         lc[i] = sc + AW'(2 * i);
         cfg_write(3'd0, L'(1) << i, lb[i]);
         cfg_write(3'd1, L'(1) << i, ls[i]);
         cfg_write(3'd2, L'(1) << i, lc[i]);
      end
      cfg_write(3'd3, '0, AW'(m));
      cfg_write(3'd4, '0, AW'(cnt));
      cur_mode = m;
      cur_cnt  = cnt;
   endtask

   task automatic stream(input bit poke);
      int groups;
      string arq;
      groups = (cur_cnt + L - 1) / L;
      arq = (cur_mode == 2'd1) ? "R3" : (cur_mode == 2'd2) ? "R4" :
            (cur_mode == 2'd3) ? "R10" : "R2";
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (cur_cnt == 0) begin
         check(idx_take_o == 1'b0, "R8", "take with zero count", idx_take_o, 0);
         @(negedge clk);
         check(done_o == 1'b1 && valid_o == '0, "R8", "done/valid zero count",
               {valid_o, done_o}, 1);
      end else begin
         for (int k = 0; k < groups; k++) begin
            for (int i = 0; i < L; i++) idx_i[i*IW +: IW] = gidx(k, i);
            check(idx_take_o == 1'b1, "R5", "idx_take in group cycle", idx_take_o, 1);
            if (poke && k == 1) begin
               cfg_we = 1'b1; cfg_field = 3'd0; cfg_lane_mask = '1;
               cfg_wdata = 20'hABCDE; start = 1'b1;
            end
            @(negedge clk);
            cfg_we = 1'b0; start = 1'b0;
            begin
               logic [L-1:0] ev;
               for (int i = 0; i < L; i++) ev[i] = (k * L + i) < cur_cnt;
               check(valid_o == ev, "R6", "valid lanes", valid_o, ev);
               for (int i = 0; i < L; i++) begin
                  if (ev[i]) begin
                     logic [AW-1:0] ea;
                     ea = exp_addr(cur_mode, k * L + i, lb[i], ls[i], lc[i], gidx(k, i));
                     check(addr_o[i*AW +: AW] == ea, poke ? "R9" : arq, "lane address",
                           addr_o[i*AW +: AW], ea);
                  end
               end
            end
         end
         check(idx_take_o == 1'b0 && done_o == 1'b0, "R7", "final cycle before done",
               {idx_take_o, done_o}, 0);
         @(negedge clk);
         check(done_o == 1'b1 && valid_o == '0, "R7", "done pulse", {valid_o, done_o}, 1);
      end
      @(negedge clk);
      check(done_o == 1'b0 && valid_o == '0 && idx_take_o == 1'b0, poke ? "R9" : "R7",
            "idle after done", {idx_take_o, valid_o, done_o}, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(valid_o == '0 && done_o == 1'b0 && idx_take_o == 1'b0, "R1", "in reset",
            {idx_take_o, valid_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid_o == '0 && done_o == 1'b0 && idx_take_o == 1'b0, "R1", "after reset",
            {idx_take_o, valid_o, done_o}, 0);

      for (int n = 0; n < 7; n++) begin
         logic [73:0] v;
         v = VECS[n];
         configure(v[73:72], int'(v[71:60]), v[59:40], v[39:20], v[19:0]);
         stream(1'b0);
      end

      // R8: zero count
      configure(2'd0, 0, 20'h00010, 20'h0, 20'h0);
      stream(1'b0);

      // R9: writes and start mid-stream are ignored, now and on the next stream
      configure(2'd2, 20, 20'h03000, 20'h0, 20'h00005);
      stream(1'b1);
      stream(1'b0);

      // R11: unused field codes change nothing
      cfg_write(3'd5, '1, 20'h12345);
      cfg_write(3'd6, '1, 20'h00001);
      cfg_write(3'd7, '1, 20'h00000);
      begin
         string keep;
         keep = "R11";
         $display("checking %s unused field codes", keep);
      end
      stream(1'b0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule